// File: doc/BRIEF.md
# Framebuffer Fill and Copy Engine

A command-driven engine that fills or copies short runs of pixels in an 8-bit-per-pixel framebuffer whose line pitch is fixed at 1024 bytes. Software talks to it through a 32-bit write window. A write with address bit 2 clear stores a colour word. A write with address bit 2 set starts an operation on up to 32 pixels. The destination pixel index is taken from the write address. The source pixel index and the run length are packed into the data word. A source index of all ones (0xFFFFFF) turns the operation into a solid fill with the stored colour.

The engine owns one single-port memory interface. It has a shared pixel address, a byte lane for the 8-bit plane and a 32-bit lane for a parallel 24-bit plane. Both lanes read synchronously: data for an address presented in one cycle comes back in the next cycle. When the 24-bit mode input is high at launch, each pixel written also writes the matching 32-bit entry of the wide plane.

The command port follows valid/ready rules. A transfer happens on a rising edge where `cmd_valid` and `cmd_ready` are both high. While an operation runs, `cmd_ready` is held low only for writes that have address bit 2 set. Reads and colour writes are still accepted, so the command master must not assume a trigger is taken until it sees ready. `busy` and `done` are plain status pins.

Top module: `fb_blit_engine`

## Requirements
- R1: An accepted write of a word (`cmd_size` = 2'b10, `cmd_addr[1:0]` = 0) with `cmd_addr[2]` = 0 stores all 32 data bits as the pending colour. It causes no memory write and does not raise busy.
- R2: An accepted word write with `cmd_addr[2]` = 1 launches an operation. Its destination pixel index is `cmd_addr[22:3]`, and address bits above bit 22 are ignored.
- R3: The run length is `cmd_wdata[28:24]` + 1, giving 1 to 32 pixels. Exactly that many byte writes occur, at strictly ascending addresses starting at the destination.
- R4: When `cmd_wdata[23:0]` is 0xFFFFFF the operation is a fill. Every destination byte receives bits 7:0 of the colour captured at launch, one write per cycle, so busy lasts as many cycles as the length.
- R5: Any other source index is a copy. Byte i is read at source+i and then written at destination+i, taking two cycles per byte in ascending order. Overlapping runs are not corrected, so the result equals a forward byte-by-byte copy.
- R6: `mode24` is sampled at launch. When it is high, a fill also writes {8'h00, colour[23:0]} to the wide plane at each destination pixel, and a copy also copies the wide entries. When it is low, `mem_we24` never asserts.
- R7: Reads (`cmd_we` = 0) are accepted at any time. They return `cmd_rdata` = 0 and have no effect.
- R8: Writes with `cmd_size` other than 2'b10, or with `cmd_addr[1:0]` not zero, are accepted and ignored. They launch nothing and leave the colour unchanged.
- R9: While busy, `cmd_ready` is low for writes with `cmd_addr[2]` = 1 and high for all other accesses. A colour stored during a run does not alter that run but applies to the next one.
- R10: `busy` is high from the cycle after launch through the cycle of the last memory write. `done` is high for exactly the following cycle, with `busy` low.
- R11: After reset, busy, done and both write enables are low, ready is high and the stored colour is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode24 | input | 1 | Also update the 24-bit plane (sampled at launch) |
| cmd_valid | input | 1 | Command access valid |
| cmd_ready | output | 1 | Command access accepted this edge |
| cmd_we | input | 1 | 1 write, 0 read |
| cmd_addr | input | CMD_AW | Byte address inside the command window |
| cmd_size | input | 2 | Access size code, 2'b10 is a 32-bit word |
| cmd_wdata | input | 32 | Write data |
| cmd_rdata | output | 32 | Read data, always zero |
| mem_addr | output | PIX_AW | Pixel index for both planes |
| mem_we8 | output | 1 | Byte plane write enable |
| mem_wd8 | output | 8 | Byte plane write data |
| mem_rd8 | input | 8 | Byte plane read data, one cycle after address |
| mem_we24 | output | 1 | Wide plane write enable |
| mem_wd24 | output | 32 | Wide plane write data |
| mem_rd24 | input | 32 | Wide plane read data, one cycle after address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The hardest situation to reach from the ports is a colour write that lands in the middle of a running fill, together with a trigger presented in the same window that must be held off. The stimulus launches a 32-pixel fill and then, while busy is still high, pushes a new colour through the port and probes a second trigger for ready low. It then checks that the run finished with the old colour and that a following fill uses the new one. Overlapping forward copies are reached by directed source/destination pairs a few bytes apart, and by random pairs drawn from a small address range.

// File: rtl/fb_blit_pkg.sv
package fb_blit_pkg;

  // run sequencer states
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_FILL = 2'd1,
    RS_CRD  = 2'd2,
    RS_CWR  = 2'd3
  } run_state_t;

  // access size code for a full 32-bit word
  localparam logic [1:0] SZ_WORD = 2'b10;

  // address bit that separates colour latch from trigger
  localparam int TRIG_BIT = 2;

  // first address bit of the destination pixel index
  localparam int DST_LSB = 3;

  function automatic logic is_write_slot(input logic [1:0] st);
    return (st == RS_FILL) || (st == RS_CWR);
  endfunction

endpackage

// File: rtl/fb_cmd_decode.sv
module fb_cmd_decode
  import fb_blit_pkg::*;
#(
  parameter int CMD_AW = 24,
  parameter int DST_W  = 20,
  parameter int PIX_AW = 24,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode24,
  input  logic              cmd_valid,
  input  logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [1:0]        cmd_size,
  input  logic [31:0]       cmd_wdata,
  output logic              launch,
  output logic [PIX_AW-1:0] l_dst,
  output logic [PIX_AW-1:0] l_src,
  output logic [LEN_W-1:0]  l_len_m1,
  output logic              l_fill,
  output logic              l_wide,
  output logic [31:0]       l_colour
);

  localparam int DST_TOP = DST_LSB + DST_W;

  logic        word_ok;
  logic        wr_hit;
  logic [31:0] colour_q;
  logic        unused_bits;

  assign word_ok = (cmd_size == SZ_WORD) && (cmd_addr[1:0] == 2'b00);
  assign wr_hit  = cmd_valid && cmd_ready && cmd_we && word_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) colour_q <= '0;
    else if (wr_hit && !cmd_addr[TRIG_BIT]) colour_q <= cmd_wdata;
  end

  assign launch   = wr_hit && cmd_addr[TRIG_BIT];
  assign l_dst    = PIX_AW'(cmd_addr[DST_TOP-1:DST_LSB]);
  assign l_src    = cmd_wdata[PIX_AW-1:0];
  assign l_len_m1 = cmd_wdata[PIX_AW +: LEN_W];
  assign l_fill   = &cmd_wdata[PIX_AW-1:0];
  assign l_wide   = mode24;
  assign l_colour = colour_q;

  generate
    if (CMD_AW > DST_TOP) begin : g_hi_addr
      assign unused_bits = ^{cmd_addr[CMD_AW-1:DST_TOP], cmd_wdata[31:PIX_AW+LEN_W]};
    end else begin : g_no_hi_addr
      assign unused_bits = ^cmd_wdata[31:PIX_AW+LEN_W];
    end
  endgenerate

  // malformed accesses never change the pending colour
  assert_bad_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_we && !word_ok) |=> $stable(colour_q));

endmodule

// File: rtl/fb_run_ctrl.sv
module fb_run_ctrl
  import fb_blit_pkg::*;
#(
  parameter int PIX_AW = 24,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [PIX_AW-1:0] l_dst,
  input  logic [PIX_AW-1:0] l_src,
  input  logic [LEN_W-1:0]  l_len_m1,
  input  logic              l_fill,
  input  logic              l_wide,
  input  logic [31:0]       l_colour,
  output run_state_t        state,
  output logic [PIX_AW-1:0] dptr,
  output logic [PIX_AW-1:0] sptr,
  output logic [31:0]       run_colour,
  output logic              run_wide,
  output logic              busy,
  output logic              done
);

  logic [LEN_W-1:0] left;
  logic             last_wr;

  assign busy    = (state != RS_IDLE);
  assign last_wr = is_write_slot(state) && (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RS_IDLE;
      dptr       <= '0;
      sptr       <= '0;
      left       <= '0;
      run_colour <= '0;
      run_wide   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= last_wr;
      unique case (state)
        RS_IDLE: begin
          if (launch) begin
            dptr       <= l_dst;
            sptr       <= l_src;
            left       <= l_len_m1;
            run_colour <= l_colour;
            run_wide   <= l_wide;
            state      <= l_fill ? RS_FILL : RS_CRD;
          end
        end
        RS_FILL: begin
          dptr <= dptr + 1'b1;
          left <= left - 1'b1;
          if (left == '0) state <= RS_IDLE;
        end
        RS_CRD: begin
          state <= RS_CWR;
        end
        RS_CWR: begin
          dptr <= dptr + 1'b1;
          sptr <= sptr + 1'b1;
          left <= left - 1'b1;
          state <= (left == '0) ? RS_IDLE : RS_CRD;
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  // every copy write is preceded by its read cycle
  assert_copy_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_CWR) |-> ($past(state) == RS_CRD));

  // the decoder never launches into a running operation
  assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (state == RS_IDLE));

endmodule

// File: rtl/fb_mem_drive.sv
module fb_mem_drive
  import fb_blit_pkg::*;
#(
  parameter int PIX_AW   = 24,
  parameter bit HAS_WIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  run_state_t        state,
  input  logic [PIX_AW-1:0] dptr,
  input  logic [PIX_AW-1:0] sptr,
  input  logic [31:0]       run_colour,
  input  logic              run_wide,
  input  logic [7:0]        mem_rd8,
  input  logic [31:0]       mem_rd24,
  output logic [PIX_AW-1:0] mem_addr,
  output logic              mem_we8,
  output logic [7:0]        mem_wd8,
  output logic              mem_we24,
  output logic [31:0]       mem_wd24
);

  logic is_fill;

  assign is_fill  = (state == RS_FILL);
  assign mem_addr = (state == RS_CRD) ? sptr : dptr;
  assign mem_we8  = is_write_slot(state);
  assign mem_wd8  = is_fill ? run_colour[7:0] : mem_rd8;

  generate
    if (HAS_WIDE) begin : g_wide
      assign mem_we24 = mem_we8 && run_wide;
      assign mem_wd24 = is_fill ? {8'h00, run_colour[23:0]} : mem_rd24;
    end else begin : g_narrow
      logic unused_wide;
      assign unused_wide = ^{run_wide, mem_rd24, run_colour[31:8]};
      assign mem_we24 = 1'b0;
      assign mem_wd24 = '0;
    end
  endgenerate

  // back-to-back writes (fill) step the address by one
  assert_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we8 && $past(mem_we8)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // the wide plane is only written alongside the byte plane
  assert_wide_with_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we24 |-> mem_we8);

endmodule

// File: rtl/fb_blit_engine.sv
module fb_blit_engine
  import fb_blit_pkg::*;
#(
  parameter int PIX_AW   = 24,
  parameter int DST_W    = 20,
  parameter int LEN_W    = 5,
  parameter int CMD_AW   = 24,
  parameter bit HAS_WIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode24,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [1:0]        cmd_size,
  input  logic [31:0]       cmd_wdata,
  output logic [31:0]       cmd_rdata,
  output logic [PIX_AW-1:0] mem_addr,
  output logic              mem_we8,
  output logic [7:0]        mem_wd8,
  input  logic [7:0]        mem_rd8,
  output logic              mem_we24,
  output logic [31:0]       mem_wd24,
  input  logic [31:0]       mem_rd24,
  output logic              busy,
  output logic              done
);

  logic              launch;
  logic [PIX_AW-1:0] l_dst, l_src;
  logic [LEN_W-1:0]  l_len_m1;
  logic              l_fill, l_wide;
  logic [31:0]       l_colour;
  run_state_t        state;
  logic [PIX_AW-1:0] dptr, sptr;
  logic [31:0]       run_colour;
  logic              run_wide;

  assign cmd_ready = !(busy && cmd_we && cmd_addr[TRIG_BIT]);
  assign cmd_rdata = '0;

  fb_cmd_decode #(
    .CMD_AW(CMD_AW), .DST_W(DST_W), .PIX_AW(PIX_AW), .LEN_W(LEN_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .mode24(mode24),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_wdata(cmd_wdata),
    .launch(launch), .l_dst(l_dst), .l_src(l_src), .l_len_m1(l_len_m1),
    .l_fill(l_fill), .l_wide(l_wide), .l_colour(l_colour)
  );

  fb_run_ctrl #(
    .PIX_AW(PIX_AW), .LEN_W(LEN_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .l_dst(l_dst), .l_src(l_src), .l_len_m1(l_len_m1),
    .l_fill(l_fill), .l_wide(l_wide), .l_colour(l_colour),
    .state(state), .dptr(dptr), .sptr(sptr),
    .run_colour(run_colour), .run_wide(run_wide),
    .busy(busy), .done(done)
  );

  fb_mem_drive #(
    .PIX_AW(PIX_AW), .HAS_WIDE(HAS_WIDE)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .state(state),
    .dptr(dptr), .sptr(sptr), .run_colour(run_colour), .run_wide(run_wide),
    .mem_rd8(mem_rd8), .mem_rd24(mem_rd24),
    .mem_addr(mem_addr), .mem_we8(mem_we8), .mem_wd8(mem_wd8),
    .mem_we24(mem_we24), .mem_wd24(mem_wd24)
  );

  // triggers are held off while a run is active
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_we && cmd_addr[TRIG_BIT]) |-> !cmd_ready);

  // done follows a memory write and coincides with idle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(mem_we8)));

  // no memory writes while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we8 && !mem_we24));

endmodule

// File: tb/sim_fb_blit_engine.sv
module sim_fb_blit_engine;

  localparam int MEMN = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode24 = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_we = 1'b0;
  logic [23:0] cmd_addr = '0;
  logic [1:0]  cmd_size = 2'b10;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [23:0] mem_addr;
  logic        mem_we8, mem_we24;
  logic [7:0]  mem_wd8, mem_rd8;
  logic [31:0] mem_wd24, mem_rd24;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fb_blit_engine u0 (
    .clk(clk), .rst_n(rst_n), .mode24(mode24),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata),
    .mem_addr(mem_addr), .mem_we8(mem_we8), .mem_wd8(mem_wd8), .mem_rd8(mem_rd8),
    .mem_we24(mem_we24), .mem_wd24(mem_wd24), .mem_rd24(mem_rd24),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] init8(input int i);
    return 8'((i * 37 + 11) ^ (i >> 5));
  endfunction
  function automatic logic [31:0] init24(input int i);
    return 32'(i * 32'h9E3779B1 + 7);
  endfunction

  // memory model: synchronous read, one cycle latency
  logic [7:0]  m8  [MEMN];
  logic [31:0] m24 [MEMN];
  logic [7:0]  e8  [MEMN];
  logic [31:0] e24 [MEMN];
  bit mem_init = 0;

  always @(posedge clk) begin
    if (!mem_init) begin
      for (int i = 0; i < MEMN; i++) begin
        m8[i]  <= init8(i);
        m24[i] <= init24(i);
      end
      mem_init <= 1;
    end else begin
      if (mem_we8)  m8[mem_addr[11:0]]  <= mem_wd8;
      if (mem_we24) m24[mem_addr[11:0]] <= mem_wd24;
    end
    mem_rd8  <= m8[mem_addr[11:0]];
    mem_rd24 <= m24[mem_addr[11:0]];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  // one valid/ready transfer; returns at the negedge after acceptance
  task automatic send(input logic we, input logic [23:0] a, input logic [1:0] sz,
                      input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    cmd_valid = 1; cmd_we = we; cmd_addr = a; cmd_size = sz; cmd_wdata = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    rd = cmd_rdata;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic set_colour(input logic [31:0] c);
    logic [31:0] rd;
    send(1'b1, 24'h0, 2'b10, c, rd);
  endtask

  task automatic model_op(input int dst, input logic [23:0] src, input int len,
                          input logic [31:0] col, input bit wide);
    for (int i = 0; i < len; i++) begin
      if (src == 24'hFFFFFF) begin
        e8[dst + i] = col[7:0];
        if (wide) e24[dst + i] = {8'h00, col[23:0]};
      end else begin
        e8[dst + i] = e8[int'(src) + i];
        if (wide) e24[dst + i] = e24[int'(src) + i];
      end
    end
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    for (int i = 0; i < MEMN; i++)
      if (bad < 0 && (m8[i] !== e8[i] || m24[i] !== e24[i])) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, {m24[bad], m8[bad]}, {e24[bad], e8[bad]});
  endtask

  // trigger, then measure busy length and done placement
  task automatic run_op(input int dst, input logic [23:0] src, input int len,
                        input logic [31:0] col, input logic [23:0] hi, input string req);
    logic [31:0] rd;
    int n = 0;
    int exp_n;
    bit wide = mode24;
    send(1'b1, hi | 24'(dst << 3) | 24'h4, 2'b10, {3'b000, 5'(len - 1), src}, rd);
    while (busy) begin n++; @(negedge clk); end
    exp_n = (src == 24'hFFFFFF) ? len : 2 * len;
    chk(n == exp_n, {req, " R10 busy cycles R3"}, n, exp_n);
    chk(done == 1'b1, {req, " R10 done pulse"}, done, 1);
    @(negedge clk);
    chk(done == 1'b0, {req, " R10 done one cycle"}, done, 0);
    model_op(dst, src, len, col, wide);
    check_mem(req);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] colour;
    for (int i = 0; i < MEMN; i++) begin e8[i] = init8(i); e24[i] = init24(i); end
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk(!busy && !done, "R11 busy/done after reset", {busy, done}, 0);
    chk(!mem_we8 && !mem_we24, "R11 write enables after reset", {mem_we8, mem_we24}, 0);
    chk(cmd_ready, "R11 ready after reset", cmd_ready, 1);
    // R11 colour starts at zero: fill with no colour write
    mode24 = 1;
    run_op(40, 24'hFFFFFF, 4, 32'h0, 24'h0, "R11 zero colour fill R6");

    // R1 colour write does nothing to memory
    set_colour(32'hA5C3B2E1);
    chk(!busy && !mem_we8, "R1 colour write no activity", {busy, mem_we8}, 0);
    check_mem("R1 memory untouched");
    colour = 32'hA5C3B2E1;

    // R4/R6 fill, length 32 and 1
    run_op(64, 24'hFFFFFF, 32, colour, 24'h0, "R4 fill len32 R6");
    mode24 = 0;
    run_op(200, 24'hFFFFFF, 1, colour, 24'h0, "R4 fill len1 narrow R6");

    // R5 copies, non-overlap, forward overlap, backward overlap
    run_op(300, 24'd1000, 17, colour, 24'h0, "R5 copy plain");
    mode24 = 1;
    run_op(1500, 24'd1200, 32, colour, 24'h0, "R5 copy wide R6");
    run_op(2003, 24'd2000, 20, colour, 24'h0, "R5 overlap forward");
    run_op(2500, 24'd2505, 25, colour, 24'h0, "R5 overlap backward");

    // R2 high address bit ignored
    run_op(77, 24'hFFFFFF, 3, colour, 24'h800000, "R2 masked destination");

    // R7 read has no effect and returns zero
    send(1'b0, 24'h000124, 2'b10, 32'h05FFFFFF, rd);
    chk(rd == 0, "R7 read data", rd, 0);
    chk(!busy, "R7 read launches nothing", busy, 0);
    check_mem("R7 memory untouched");

    // R8 malformed accesses ignored
    send(1'b1, 24'h000104, 2'b00, 32'h03FFFFFF, rd);
    chk(!busy, "R8 byte-size trigger ignored", busy, 0);
    send(1'b1, 24'h000105, 2'b10, 32'h03FFFFFF, rd);
    chk(!busy, "R8 misaligned trigger ignored", busy, 0);
    send(1'b1, 24'h000000, 2'b01, 32'h11111111, rd);
    run_op(900, 24'hFFFFFF, 2, colour, 24'h0, "R8 colour unchanged by bad size");
    check_mem("R8 memory after bad accesses");

    // R9 colour change mid-run and back-pressure
    send(1'b1, 24'(1000 << 3) | 24'h4, 2'b10, {3'b000, 5'd31, 24'hFFFFFF}, rd);
    set_colour(32'h00C0FFEE);
    chk(busy, "R9 colour write accepted while busy", busy, 1);
    cmd_valid = 1; cmd_we = 1; cmd_addr = 24'h000204; cmd_size = 2'b10; cmd_wdata = 32'h00FFFFFF;
    #1;
    chk(!cmd_ready, "R9 trigger stalled while busy", cmd_ready, 0);
    cmd_we = 0;
    #1;
    chk(cmd_ready, "R9 read ready while busy", cmd_ready, 1);
    cmd_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    model_op(1000, 24'hFFFFFF, 32, colour, 1);
    check_mem("R9 run kept launch colour");
    colour = 32'h00C0FFEE;
    run_op(1100, 24'hFFFFFF, 5, colour, 24'h0, "R9 new colour on next run");

    // random mix
    for (int k = 0; k < 80; k++) begin
      int len = 1 + int'($urandom % 32);
      int dst = int'($urandom % (MEMN - 40));
      logic [23:0] src;
      mode24 = $urandom % 2;
      if ($urandom % 3 == 0) begin
        colour = $urandom;
        set_colour(colour);
      end
      if ($urandom % 2 == 0) src = 24'hFFFFFF;
      else src = 24'($urandom % (MEMN - 40));
      run_op(dst, src, len, colour, 24'h0, "R3 random R4 R5");
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule